// File: doc/BRIEF.md
# SDRAM Burst Termination Command Sequencer

This block turns user requests into commands for a single-rank SDR SDRAM. It drives the chip-select, row, column and write-enable strobes, the address bus during mode and precharge commands, the write data path with its DQM mask, and a flag that marks each returned read beat. Read and write bursts of 4 or 8 beats can be cut short. A burst-stop ends a burst at once. A precharge ends a write only after the write-recovery gap, and the sequencer masks any write beat that falls inside that gap.

After a read is terminated, the read-valid flag keeps running for the beats still in the CAS-latency pipeline and then stops. A mode-set request programs the burst length and the CAS latency. If a row is open when mode-set is requested, the sequencer first issues a precharge-all on its own. It then waits out the row-precharge time before the mode command and the mode-set recovery time after it. Requests use a valid/ready handshake. Any request that would break a timing gap is held with ready low until the gap has passed, and no request is ever lost.

Top module: `sdram_term_seq`

## Requirements
- R1: After reset the command output is NOP, and dq_oe_o, dqm_o and rd_valid_o are low. Command codes on cmd_o = {cs_n, ras_n, cas_n, we_n} are:
  - ACT 0011
  - RD 0101
  - WR 0100
  - STOP 0110
  - PRE 0010, with addr_o bit 10 set
  - MRS 0000
  - NOP 0111 in every cycle with no command

  addr_o is zero for every command except PRE and MRS. Request op codes on req_op_i are ACT=0, RD=1, WR=2, STOP=3, PRE=4, MRS=5.
- R2: A request accepted at a clock edge (req_valid_i and req_ready_o both high) drives its command in the cycle that this edge starts.
- R3: A write drives BL beats, one per cycle, starting in the WR cycle. In each beat dq_oe_o is high, dqm_o is low and dq_o equals wr_data_i.
- R4: A STOP accepted during a write ends the burst. No beat is driven in the STOP cycle or after it, so the last kept beat is exactly 1 cycle before the STOP.
- R5: A PRE is issued no sooner than 2 cycles after the last kept write beat. If PRE is requested while two or more beats of a write remain, the next beat is driven with dqm_o high and the PRE follows in the cycle after it. If PRE is requested during the final beat, nothing is masked.
- R6: rd_valid_o is high from cycle RD+CL for BL consecutive cycles. CL is the CAS latency and BL is the burst length.
- R7: When a read is ended by STOP or PRE in cycle s, rd_valid_o goes low after cycle s+CL-1. That leaves exactly 1 trailing beat at CL 2 and 2 at CL 3.
- R8: MRS loads req_mode_i: bit 0 set selects BL 8 (clear selects 4), and bit 1 set selects CL 3 (clear selects 2). addr_o[2:0] carries 010 or 011 for BL 4 or 8, and addr_o[6:4] carries 010 or 011 for CL 2 or 3. The reset mode is BL 4, CL 2.
- R9: MRS requested while a row is open first issues PRE (precharge-all) without handshake. The MRS follows exactly TRP cycles after that PRE.
- R10: After an MRS in cycle m, the next command comes no earlier than cycle m+TMRD.
- R11: A held-off request is kept and issued at the first allowed cycle. An ACT requested right after a PRE issues exactly TRP cycles after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Request accepted at this edge |
| req_op_i | input | 3 | Request op code |
| req_mode_i | input | 2 | Mode value for MRS: bit 0 selects BL 8, bit 1 selects CL 3 |
| wr_data_i | input | DW | Write data for the current beat |
| cmd_o | output | 4 | {cs_n, ras_n, cas_n, we_n} |
| addr_o | output | AW | Address bus during PRE and MRS |
| dqm_o | output | 1 | Data mask for the current write beat |
| dq_oe_o | output | 1 | Write data driven this cycle |
| dq_o | output | DW | Write data |
| rd_valid_o | output | 1 | A read data beat returns this cycle |

## Verification
Writes are run three ways:
- to completion, which shows the burst length;
- cut by STOP right after the WR, which separates the 1-cycle stop gap from the masked path;
- cut by PRE either early or during the last beat, which shows whether a mask beat is inserted or only a wait.

Reads are run to completion at CL 2 and at CL 3, cut by STOP at CL 3 and cut by PRE at CL 2. Together these tell apart a latency fault, a missing trim and a trim length that ignores CL. Mode set is tried with the bank closed and with it open, which shows whether the automatic precharge and the TRP and TMRD waits are applied.

// File: rtl/sdram_term_pkg.sv
package sdram_term_pkg;
  typedef enum logic [2:0] {
    OP_ACT  = 3'd0,
    OP_RD   = 3'd1,
    OP_WR   = 3'd2,
    OP_STOP = 3'd3,
    OP_PRE  = 3'd4,
    OP_MRS  = 3'd5
  } op_e;

  // {cs_n, ras_n, cas_n, we_n}
  localparam logic [3:0] CMD_NOP  = 4'b0111;
  localparam logic [3:0] CMD_ACT  = 4'b0011;
  localparam logic [3:0] CMD_RD   = 4'b0101;
  localparam logic [3:0] CMD_WR   = 4'b0100;
  localparam logic [3:0] CMD_STOP = 4'b0110;
  localparam logic [3:0] CMD_PRE  = 4'b0010;
  localparam logic [3:0] CMD_MRS  = 4'b0000;
endpackage

// File: rtl/sdram_beat_ctr.sv
module sdram_beat_ctr #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] len_i,
  input  logic         kill_i,
  output logic [W-1:0] cnt_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (load_i)          cnt_q <= len_i;
    else if (kill_i)          cnt_q <= '0;
    else if (cnt_q != '0)     cnt_q <= cnt_q - W'(1);
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/sdram_rd_trim.sv
module sdram_rd_trim #(
  parameter int MAX_CL = 3,
  parameter int CLW    = $clog2(MAX_CL + 1)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           token_i,
  input  logic [CLW-1:0] cl_i,
  output logic           valid_o,
  output logic           pend_o
);
  logic [MAX_CL-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= '0;
    else         sr_q <= {sr_q[MAX_CL-2:0], token_i};
  end

  // tap i holds a token issued i+1 cycles ago
  always_comb begin
    valid_o = 1'b0;
    for (int i = 0; i < MAX_CL; i++)
      if (cl_i == CLW'(i + 1)) valid_o = sr_q[i];
  end

  assign pend_o = |sr_q;
endmodule

// File: rtl/sdram_term_seq.sv
module sdram_term_seq
  import sdram_term_pkg::*;
#(
  parameter int DW     = 16,
  parameter int AW     = 12,
  parameter int TRP    = 3,
  parameter int TMRD   = 2,
  parameter int MAX_BL = 8,
  parameter int MAX_CL = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  output logic          req_ready_o,
  input  logic [2:0]    req_op_i,
  input  logic [1:0]    req_mode_i,
  input  logic [DW-1:0] wr_data_i,
  output logic [3:0]    cmd_o,
  output logic [AW-1:0] addr_o,
  output logic          dqm_o,
  output logic          dq_oe_o,
  output logic [DW-1:0] dq_o,
  output logic          rd_valid_o
);
  localparam int BLW = $clog2(MAX_BL + 1);
  localparam int RPW = $clog2(TRP + 1);
  localparam int MDW = $clog2(TMRD + 1);
  localparam int CLW = $clog2(MAX_CL + 1);

  op_e            op;
  logic [BLW-1:0] wr_cnt, rd_cnt, bl_len;
  logic [RPW-1:0] rp_cnt;
  logic [MDW-1:0] mrd_cnt;
  logic [CLW-1:0] cl_q;
  logic           bl8_q, bank_open_q, mask_q;
  logic           wr_busy, rd_busy, rp_busy, mrd_busy, rd_pend;
  logic           idle, rdy, fire, auto_pre, mask_go, kept;
  logic [3:0]     cmd_d, cmd_q;
  logic [AW-1:0]  addr_d, addr_q;

  assign op       = op_e'(req_op_i);
  assign bl_len   = bl8_q ? BLW'(8) : BLW'(4);
  assign wr_busy  = wr_cnt != '0;
  assign rd_busy  = rd_cnt != '0;
  assign rp_busy  = rp_cnt != '0;
  assign mrd_busy = mrd_cnt != '0;
  assign idle     = !wr_busy && !rd_busy && !mask_q && !mrd_busy;

  always_comb begin
    unique case (op)
      OP_ACT:       rdy = idle && !rp_busy;
      OP_RD, OP_WR: rdy = idle;
      OP_STOP:      rdy = !mrd_busy;
      OP_PRE:       rdy = !mrd_busy && !wr_busy;
      OP_MRS:       rdy = idle && !rd_pend && !rp_busy && !bank_open_q;
      default:      rdy = 1'b1;
    endcase
  end

  assign req_ready_o = rdy;
  assign fire        = req_valid_i && rdy;
  assign auto_pre    = req_valid_i && op == OP_MRS && idle && !rd_pend && !rp_busy && bank_open_q;
  // PRE during a running write: mask the next beat to open the recovery gap
  assign mask_go     = req_valid_i && op == OP_PRE && !mrd_busy && wr_cnt > BLW'(1);

  always_comb begin
    cmd_d  = CMD_NOP;
    addr_d = '0;
    if (auto_pre) begin
      cmd_d      = CMD_PRE;
      addr_d[10] = 1'b1;
    end else if (fire) begin
      unique case (op)
        OP_ACT:  cmd_d = CMD_ACT;
        OP_RD:   cmd_d = CMD_RD;
        OP_WR:   cmd_d = CMD_WR;
        OP_STOP: cmd_d = CMD_STOP;
        OP_PRE: begin
          cmd_d      = CMD_PRE;
          addr_d[10] = 1'b1;
        end
        OP_MRS: begin
          cmd_d       = CMD_MRS;
          addr_d[2:0] = req_mode_i[0] ? 3'b011 : 3'b010;
          addr_d[6:4] = req_mode_i[1] ? 3'b011 : 3'b010;
        end
        default: cmd_d = CMD_NOP;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q       <= CMD_NOP;
      addr_q      <= '0;
      mask_q      <= 1'b0;
      bank_open_q <= 1'b0;
      bl8_q       <= 1'b0;
      cl_q        <= CLW'(2);
    end else begin
      cmd_q  <= cmd_d;
      addr_q <= addr_d;
      mask_q <= mask_go;
      if (fire && op == OP_ACT) bank_open_q <= 1'b1;
      else if (auto_pre || (fire && op == OP_PRE)) bank_open_q <= 1'b0;
      if (fire && op == OP_MRS) begin
        bl8_q <= req_mode_i[0];
        cl_q  <= req_mode_i[1] ? CLW'(3) : CLW'(2);
      end
    end
  end

  sdram_beat_ctr #(.W(BLW)) i_wr_ctr (
    .clk_i, .rst_ni,
    .load_i(fire && op == OP_WR), .len_i(bl_len),
    .kill_i((fire && op == OP_STOP) || mask_go), .cnt_o(wr_cnt)
  );

  sdram_beat_ctr #(.W(BLW)) i_rd_ctr (
    .clk_i, .rst_ni,
    .load_i(fire && op == OP_RD), .len_i(bl_len),
    .kill_i(fire && (op == OP_STOP || op == OP_PRE)), .cnt_o(rd_cnt)
  );

  sdram_beat_ctr #(.W(RPW)) i_rp_ctr (
    .clk_i, .rst_ni,
    .load_i(auto_pre || (fire && op == OP_PRE)), .len_i(RPW'(TRP - 1)),
    .kill_i(1'b0), .cnt_o(rp_cnt)
  );

  sdram_beat_ctr #(.W(MDW)) i_mrd_ctr (
    .clk_i, .rst_ni,
    .load_i(fire && op == OP_MRS), .len_i(MDW'(TMRD - 1)),
    .kill_i(1'b0), .cnt_o(mrd_cnt)
  );

  sdram_rd_trim #(.MAX_CL(MAX_CL), .CLW(CLW)) i_rd_trim (
    .clk_i, .rst_ni,
    .token_i(rd_busy), .cl_i(cl_q),
    .valid_o(rd_valid_o), .pend_o(rd_pend)
  );

  assign cmd_o   = cmd_q;
  assign addr_o  = addr_q;
  assign dqm_o   = mask_q;
  assign dq_oe_o = wr_busy || mask_q;
  assign dq_o    = dq_oe_o ? wr_data_i : '0;
  assign kept    = dq_oe_o && !dqm_o;

  assert_stop_no_beat_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_o == CMD_STOP |-> !kept);

  assert_pre_recovery_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_o == CMD_PRE |-> !kept && !$past(kept));

  assert_mask_then_pre_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dqm_o |=> cmd_o == CMD_PRE);

  assert_trim_cl2_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_o == CMD_STOP || cmd_o == CMD_PRE) && cl_q == CLW'(2) |-> ##2 !rd_valid_o);

  assert_trim_cl3_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_o == CMD_STOP || cmd_o == CMD_PRE) && cl_q == CLW'(3) |-> ##3 !rd_valid_o);

  assert_mrs_bank_closed_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_o == CMD_MRS |-> !$past(bank_open_q));

  generate
    if (TRP >= 2) begin : g_rp_chk
      assert_mrs_after_rp_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cmd_o == CMD_MRS |-> $past(cmd_o) != CMD_PRE);
    end
    if (TMRD >= 2) begin : g_mrd_chk
      assert_mrd_quiet_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cmd_o == CMD_MRS |=> cmd_o == CMD_NOP);
    end
  endgenerate
endmodule

// File: tb/test_sdram_term_seq.sv
module test_sdram_term_seq;
  import sdram_term_pkg::*;
  localparam int DW = 16, AW = 12, TRP = 3, TMRD = 2;

  logic          clk = 1'b0, rst_n = 1'b0;
  logic          req_valid, req_ready;
  logic [2:0]    req_op;
  logic [1:0]    req_mode;
  logic [DW-1:0] wr_data, dq;
  logic [3:0]    cmd;
  logic [AW-1:0] addr;
  logic          dqm, dq_oe, rd_valid;

  always #5 clk = ~clk;

  sdram_term_seq #(.DW(DW), .AW(AW), .TRP(TRP), .TMRD(TMRD)) i_sdram_term_seq (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_op_i(req_op), .req_mode_i(req_mode), .wr_data_i(wr_data), .cmd_o(cmd),
    .addr_o(addr), .dqm_o(dqm), .dq_oe_o(dq_oe), .dq_o(dq), .rd_valid_o(rd_valid)
  );

  int total = 0, bad = 0, cyc = 0;
  int kept_n, first_kept, last_kept, mask_n, rv_n, rv_first, rv_last;
  int cmd_at[16];
  logic [15:0] exp_q[$];
  logic [15:0] exp_item;
  bit tb_open = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) if (rst_n) begin
    if (cmd != CMD_NOP) begin
      cmd_at[cmd] = cyc;
      if (exp_q.size() == 0) chk(1'b0, "R1 unexpected command", int'(cmd), int'(CMD_NOP));
      else begin
        exp_item = exp_q.pop_front();
        chk({cmd, addr} == exp_item, "R1 command/address", int'({cmd, addr}), int'(exp_item));
      end
    end
    if (dq_oe && !dqm) begin
      if (kept_n == 0) first_kept = cyc;
      kept_n++;
      last_kept = cyc;
      if (dq != wr_data) chk(1'b0, "R3 write data", int'(dq), int'(wr_data));
    end
    if (dqm) mask_n++;
    if (rd_valid) begin
      if (rv_n == 0) rv_first = cyc;
      rv_n++;
      rv_last = cyc;
    end
  end

  task automatic clr();
    kept_n = 0; mask_n = 0; rv_n = 0;
    first_kept = -1; last_kept = -1; rv_first = -1; rv_last = -1;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  // called just after a falling edge; returns with the command visible
  task automatic send(op_e op, logic [1:0] mode, output int acc);
    bit go;
    case (op)
      OP_ACT:  begin exp_q.push_back({CMD_ACT, 12'h000}); tb_open = 1'b1; end
      OP_RD:   exp_q.push_back({CMD_RD, 12'h000});
      OP_WR:   exp_q.push_back({CMD_WR, 12'h000});
      OP_STOP: exp_q.push_back({CMD_STOP, 12'h000});
      OP_PRE:  begin exp_q.push_back({CMD_PRE, 12'h400}); tb_open = 1'b0; end
      OP_MRS: begin
        if (tb_open) exp_q.push_back({CMD_PRE, 12'h400});
        exp_q.push_back({CMD_MRS, 5'b0, mode[1] ? 3'b011 : 3'b010, 1'b0,
                         mode[0] ? 3'b011 : 3'b010});
        tb_open = 1'b0;
      end
      default: ;
    endcase
    req_op = op; req_mode = mode; req_valid = 1'b1;
    forever begin
      #1 go = req_ready;
      @(negedge clk); #1;
      if (go) break;
    end
    acc = cyc;
    req_valid = 1'b0;
  endtask

  initial begin
    int a, w, p, r, s, m;
    req_valid = 1'b0; req_op = '0; req_mode = '0; wr_data = 16'hC35A;
    clr();
    repeat (3) @(negedge clk);
    chk(cmd == CMD_NOP, "R1 reset cmd", int'(cmd), int'(CMD_NOP));
    chk(!dq_oe && !dqm, "R1 reset dq_oe/dqm", int'({dq_oe, dqm}), 0);
    chk(!rd_valid, "R1 reset rd_valid", int'(rd_valid), 0);
    rst_n = 1'b1;
    idle(2);

    // full BL4 write
    send(OP_ACT, 2'b00, a);
    clr(); send(OP_WR, 2'b00, w); idle(6);
    chk(cmd_at[CMD_WR] == w, "R2 command in accept cycle", cmd_at[CMD_WR], w);
    chk(kept_n == 4, "R3 BL4 write beats", kept_n, 4);
    chk(first_kept == w, "R3 first beat with WR", first_kept, w);

    // write cut by STOP
    clr(); send(OP_WR, 2'b00, w); send(OP_STOP, 2'b00, s); idle(6);
    chk(kept_n == 1, "R4 beats before stop", kept_n, 1);
    chk(s - last_kept == 1, "R4 stop gap", s - last_kept, 1);

    // write cut early by PRE: masked beat then PRE
    clr(); send(OP_WR, 2'b00, w); send(OP_PRE, 2'b00, p); idle(6);
    chk(mask_n == 1, "R5 masked beat", mask_n, 1);
    chk(p - last_kept == 2, "R5 pre recovery (early)", p - last_kept, 2);
    chk(p == w + 2, "R5 pre cycle", p, w + 2);

    // PRE during last beat: no mask, ACT waits TRP
    send(OP_ACT, 2'b00, a);
    clr(); send(OP_WR, 2'b00, w); idle(3); send(OP_PRE, 2'b00, p);
    send(OP_ACT, 2'b00, a); idle(4);
    chk(kept_n == 4 && mask_n == 0, "R5 no mask at burst end", mask_n, 0);
    chk(p - last_kept == 2, "R5 pre recovery (end)", p - last_kept, 2);
    chk(a - p == TRP, "R11 ACT held for TRP", a - p, TRP);

    // CL2 BL4 read
    clr(); send(OP_RD, 2'b00, r); idle(8);
    chk(rv_n == 4, "R6 CL2 beats", rv_n, 4);
    chk(rv_first == r + 2, "R6 CL2 latency", rv_first, r + 2);

    // mode set to BL8 CL3 with bank closed
    send(OP_PRE, 2'b00, p); send(OP_MRS, 2'b11, m);
    chk(m - p == TRP, "R11 MRS held for TRP", m - p, TRP);
    send(OP_ACT, 2'b00, a);
    chk(a - m == TMRD, "R10 mode-set recovery", a - m, TMRD);
    clr(); send(OP_WR, 2'b00, w); idle(10);
    chk(kept_n == 8, "R8 BL8 write beats", kept_n, 8);
    clr(); send(OP_RD, 2'b00, r); idle(12);
    chk(rv_n == 8, "R8 BL8 read beats", rv_n, 8);
    chk(rv_first == r + 3, "R6 CL3 latency", rv_first, r + 3);

    // CL3 read cut by STOP
    clr(); send(OP_RD, 2'b00, r); idle(3); send(OP_STOP, 2'b00, s); idle(8);
    chk(rv_n == 4, "R7 CL3 beats after stop", rv_n, 4);
    chk(rv_last == s + 2, "R7 CL3 trim end", rv_last, s + 2);

    // mode set with open bank: auto PRE, back to BL4 CL2
    send(OP_MRS, 2'b00, m);
    chk(m - cmd_at[CMD_PRE] == TRP, "R9 auto PRE then TRP", m - cmd_at[CMD_PRE], TRP);
    send(OP_ACT, 2'b00, a);
    chk(a - m == TMRD, "R10 ACT after mode set", a - m, TMRD);

    // CL2 read cut by PRE
    clr(); send(OP_RD, 2'b00, r); send(OP_PRE, 2'b00, s); idle(8);
    chk(rv_n == 1, "R7 CL2 beats after pre", rv_n, 1);
    chk(rv_last == s + 1, "R7 CL2 trim end", rv_last, s + 1);
    chk(exp_q.size() == 0, "R11 all requests issued", exp_q.size(), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    chk(1'b0, "R11 watchdog expired", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule